// File: doc/BRIEF.md
# Divided-Clock Phase Frequency Detector

This block measures how far a reference timing signal and a locally generated clock drift apart. The block runs on the local clock. Both sources pass through their own programmable divider, and each divider divides by its setting plus two. The reference divider runs in the reference clock's own domain. Its output is carried into the local domain through a two-flop synchronizer, and only its rising edges are counted there. The local divider produces one event for every `loc_div_set + 2` enabled local clock cycles.

A strobe generator first derives a phase-update enable once every `PI_DIV` local cycles. It then counts those enables and fires a slower loop-update strobe once every `dsp_rate + 1` of them. Each time the strobe fires, the difference between the reference event count and the local event count over the window just closed is saturated to a signed word. That word is presented together with an overflow flag, and both counters restart from zero. A downstream loop filter consumes `err` on each `dsp_stb` pulse. When the loop is locked, the word stays close to zero.

Top module: `div_phase_detector`

## Requirements
- R1: Each rising edge of the reference divider output becomes exactly one reference event. That output has one rising edge per `ref_div_set + 2` enabled `ref_clk` cycles.
- R2: The local divider produces exactly one event per `loc_div_set + 2` enabled `clk` cycles and never produces two events in adjacent cycles.
- R3: With `ref_ce` at 0 no reference events are counted, and with `loc_ce` at 0 no local events are counted. Both enables are held at 1 in normal operation.
- R4: `dsp_stb` is a one-cycle pulse with a period of `(dsp_rate + 1) * PI_DIV` clock cycles. With `PI_DIV` = 2, the suggested setting `dsp_rate` = 16'h07FF gives 4096 cycles.
- R5: `err` equals the reference events minus the local events counted in the window that closed. It changes only in a cycle where `dsp_stb` is 1 and holds its value otherwise. `err` is a two's complement number.
- R6: When the difference lies outside the signed `ERR_W`-bit range, `err` takes the nearest bound (`2^(ERR_W-1)-1` or `-2^(ERR_W-1)`) and `err_ovf` is 1 for that window. Otherwise `err_ovf` is 0.
- R7: Reset is synchronous and active-high and is held for at least eight cycles. During reset and after it, up to the first strobe, `err` reads 0 and `err_ovf` and `dsp_stb` read 0.
- R8: When the two divided frequencies are equal, every window result lies between -1 and +1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Local clock; all outputs are synchronous to it |
| rst | input | 1 | Synchronous active-high reset |
| ref_clk | input | 1 | Reference clock or pulse train, asynchronous to `clk` |
| ref_ce | input | 1 | Count enable of the reference divider |
| loc_ce | input | 1 | Count enable of the local divider |
| ref_div_set | input | SET_W | Reference division setting; divides by value + 2 |
| loc_div_set | input | SET_W | Local division setting; divides by value + 2 |
| dsp_rate | input | RATE_W | Number of phase-update enables per window, minus one |
| err | output | ERR_W | Signed, saturated event-count difference of the last window |
| err_ovf | output | 1 | The last window's difference was saturated |
| dsp_stb | output | 1 | One-cycle strobe that marks a new `err` value |

## Verification
A stuck or miscounting divider appears as a steady bias in `err`. The bias shows within two windows and is as large as the missing or extra events per window. A broken strobe counter shows as a wrong distance between `dsp_stb` pulses on the first measured interval. Faults in the saturation logic show only when a window exceeds the signed range, so a narrow-error instance drives that case to make `err` and `err_ovf` reveal them on the first full window.

// File: rtl/pfd_pkg.sv
package pfd_pkg;
  // suggested loop-update setting
  localparam logic [15:0] DSP_RATE_SUGGESTED = 16'h07FF;

  // cycles between two loop-update strobes
  function automatic int unsigned window_cycles(input int unsigned rate, input int unsigned pi_div);
    return (rate + 1) * pi_div;
  endfunction
endpackage

// File: rtl/pfd_ref_divider.sv
module pfd_ref_divider #(
  parameter int SET_W = 16
) (
  input  logic             ref_clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [SET_W-1:0] div_set,
  output logic             div_out
);
  localparam int CW = SET_W + 1;

  logic [1:0]    rst_sync;
  logic [CW-1:0] cnt;
  logic [CW-1:0] last_cnt;
  logic [CW-1:0] half_cnt;
  logic [CW-1:0] cnt_nxt;

  // reset brought into the reference domain
  always_ff @(posedge ref_clk) rst_sync <= {rst_sync[0], rst};

  assign last_cnt = {1'b0, div_set} + CW'(1);
  assign half_cnt = ({1'b0, div_set} + CW'(2)) >> 1;
  assign cnt_nxt  = (cnt == last_cnt) ? '0 : cnt + CW'(1);

  always_ff @(posedge ref_clk) begin
    if (rst_sync[1]) begin
      cnt     <= '0;
      div_out <= 1'b0;
    end else if (ce) begin
      cnt     <= cnt_nxt;
      div_out <= (cnt_nxt < half_cnt);
    end
  end
endmodule

// File: rtl/pfd_edge_sync.sv
module pfd_edge_sync (
  input  logic clk,
  input  logic rst,
  input  logic async_in,
  output logic rise
);
  logic [2:0] stage;

  always_ff @(posedge clk) begin
    if (rst) begin
      stage <= '0;
      rise  <= 1'b0;
    end else begin
      stage <= {stage[1:0], async_in};
      rise  <= stage[1] & ~stage[2];
    end
  end

  AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    rise |=> !rise); // R1
endmodule

// File: rtl/pfd_local_divider.sv
module pfd_local_divider #(
  parameter int SET_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ce,
  input  logic [SET_W-1:0] div_set,
  output logic             evt
);
  localparam int CW = SET_W + 1;

  logic [CW-1:0] cnt;
  logic          wrap;

  assign wrap = (cnt == ({1'b0, div_set} + CW'(1)));

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      evt <= 1'b0;
    end else if (ce) begin
      cnt <= wrap ? '0 : cnt + CW'(1);
      evt <= wrap;
    end else begin
      evt <= 1'b0;
    end
  end

  AST_LOC_EVT_SPACED: assert property (@(posedge clk) disable iff (rst)
    evt |=> !evt); // R2
endmodule

// File: rtl/pfd_strobe_gen.sv
module pfd_strobe_gen #(
  parameter int PI_DIV = 2,
  parameter int RATE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [RATE_W-1:0] dsp_rate,
  output logic              dsp_fire
);
  logic              pi_stb;
  logic [RATE_W-1:0] dcnt;

  generate
    if (PI_DIV <= 1) begin : g_pi_every
      assign pi_stb = 1'b1;
    end else begin : g_pi_div
      localparam int PW = $clog2(PI_DIV);
      logic [PW-1:0] pi_cnt;
      logic          pi_q;
      always_ff @(posedge clk) begin
        if (rst) begin
          pi_cnt <= '0;
          pi_q   <= 1'b0;
        end else begin
          pi_cnt <= (pi_cnt == PW'(PI_DIV - 1)) ? '0 : pi_cnt + PW'(1);
          pi_q   <= (pi_cnt == PW'(PI_DIV - 1));
        end
      end
      assign pi_stb = pi_q;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) dcnt <= '0;
    else if (pi_stb) dcnt <= (dcnt == dsp_rate) ? '0 : dcnt + RATE_W'(1);
  end

  assign dsp_fire = pi_stb && (dcnt == dsp_rate);

  // checker: distance between successive strobes
  logic [31:0] gap;
  logic        seen;
  always_ff @(posedge clk) begin
    if (rst) begin
      gap  <= '0;
      seen <= 1'b0;
    end else if (dsp_fire) begin
      gap  <= '0;
      seen <= 1'b1;
    end else begin
      gap <= gap + 32'd1;
    end
  end

  AST_DSP_PERIOD: assert property (@(posedge clk) disable iff (rst)
    (dsp_fire && seen) |-> (gap == pfd_pkg::window_cycles(32'(dsp_rate), PI_DIV) - 1)); // R4
endmodule

// File: rtl/div_phase_detector.sv
module div_phase_detector #(
  parameter int SET_W  = 16,
  parameter int RATE_W = 16,
  parameter int ERR_W  = 21,
  parameter int CNT_W  = 24,
  parameter int PI_DIV = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_clk,
  input  logic              ref_ce,
  input  logic              loc_ce,
  input  logic [SET_W-1:0]  ref_div_set,
  input  logic [SET_W-1:0]  loc_div_set,
  input  logic [RATE_W-1:0] dsp_rate,
  output logic [ERR_W-1:0]  err,
  output logic              err_ovf,
  output logic              dsp_stb
);
  localparam int DW = CNT_W + 2;
  localparam logic signed [DW-1:0] ERR_MAX = {{(DW-ERR_W+1){1'b0}}, {(ERR_W-1){1'b1}}};
  localparam logic signed [DW-1:0] ERR_MIN = {{(DW-ERR_W+1){1'b1}}, {(ERR_W-1){1'b0}}};

  // named internal events
  logic ref_div_out;
  logic ref_evt;
  logic loc_evt;
  logic dsp_fire;

  logic [CNT_W-1:0] ref_cnt, loc_cnt;
  logic [CNT_W:0]   ref_close, loc_close;
  logic [ERR_W:0]   sat_res;

  // saturating event count step
  function automatic logic [CNT_W-1:0] bump(input logic [CNT_W-1:0] c, input logic e);
    if (e && !(&c)) return c + CNT_W'(1);
    return c;
  endfunction

  // signed difference clipped to ERR_W bits; MSB of result = clipped
  function automatic logic [ERR_W:0] clip_diff(input logic [CNT_W:0] r, input logic [CNT_W:0] l);
    logic signed [DW-1:0] d;
    d = $signed({1'b0, r}) - $signed({1'b0, l});
    if (d > ERR_MAX) return {1'b1, ERR_MAX[ERR_W-1:0]};
    if (d < ERR_MIN) return {1'b1, ERR_MIN[ERR_W-1:0]};
    return {1'b0, d[ERR_W-1:0]};
  endfunction

  pfd_ref_divider #(.SET_W(SET_W)) ref_div_i (
    .ref_clk(ref_clk), .rst(rst), .ce(ref_ce), .div_set(ref_div_set), .div_out(ref_div_out)
  );

  pfd_edge_sync ref_sync_i (
    .clk(clk), .rst(rst), .async_in(ref_div_out), .rise(ref_evt)
  );

  pfd_local_divider #(.SET_W(SET_W)) loc_div_i (
    .clk(clk), .rst(rst), .ce(loc_ce), .div_set(loc_div_set), .evt(loc_evt)
  );

  pfd_strobe_gen #(.PI_DIV(PI_DIV), .RATE_W(RATE_W)) stb_i (
    .clk(clk), .rst(rst), .dsp_rate(dsp_rate), .dsp_fire(dsp_fire)
  );

  // events in the closing cycle belong to the closing window
  assign ref_close = {1'b0, ref_cnt} + (CNT_W+1)'(ref_evt);
  assign loc_close = {1'b0, loc_cnt} + (CNT_W+1)'(loc_evt);
  assign sat_res   = clip_diff(ref_close, loc_close);

  always_ff @(posedge clk) begin
    if (rst) begin
      ref_cnt <= '0;
      loc_cnt <= '0;
      err     <= '0;
      err_ovf <= 1'b0;
      dsp_stb <= 1'b0;
    end else begin
      dsp_stb <= dsp_fire;
      if (dsp_fire) begin
        err     <= sat_res[ERR_W-1:0];
        err_ovf <= sat_res[ERR_W];
        ref_cnt <= '0;
        loc_cnt <= '0;
      end else begin
        ref_cnt <= bump(ref_cnt, ref_evt);
        loc_cnt <= bump(loc_cnt, loc_evt);
      end
    end
  end

  AST_OVF_AT_RAIL: assert property (@(posedge clk) disable iff (rst)
    err_ovf |-> (err == ERR_MAX[ERR_W-1:0] || err == ERR_MIN[ERR_W-1:0])); // R6
  AST_ERR_HOLD: assert property (@(posedge clk) disable iff (rst)
    !dsp_stb |-> $stable(err)); // R5
  AST_FIRST_ZERO: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (err == '0 && !err_ovf && !dsp_stb)); // R7
endmodule

// File: tb/div_phase_detector_tb_top.sv
module div_phase_detector_tb_top;
  logic clk = 1'b0;
  logic ref_clk = 1'b0;
  logic rst = 1'b1;
  logic ref_ce = 1'b1, loc_ce = 1'b1;
  logic [15:0] ref_set = 16'd14, loc_set = 16'd6, rate = 16'd31;
  logic [20:0] err;
  logic err_ovf, dsp_stb;
  // narrow-error instance for saturation
  logic [15:0] s_loc_set = 16'd0;
  logic [3:0]  s_err;
  logic        s_ovf, s_stb;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #4 clk = ~clk;                 // 125 MHz
  initial begin #1.3; forever #2 ref_clk = ~ref_clk; end  // 4 ns reference

  div_phase_detector dut_i (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .ref_ce(ref_ce), .loc_ce(loc_ce),
    .ref_div_set(ref_set), .loc_div_set(loc_set), .dsp_rate(rate),
    .err(err), .err_ovf(err_ovf), .dsp_stb(dsp_stb)
  );

  div_phase_detector #(.ERR_W(4), .CNT_W(8)) dut_s (
    .clk(clk), .rst(rst), .ref_clk(ref_clk), .ref_ce(1'b0), .loc_ce(1'b1),
    .ref_div_set(16'd0), .loc_div_set(s_loc_set), .dsp_rate(16'd31),
    .err(s_err), .err_ovf(s_ovf), .dsp_stb(s_stb)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int serr();
    return int'($signed(err));
  endfunction

  task automatic wait_stb();
    int n = 0;
    do begin @(negedge clk); n++; end while (!dsp_stb && n < 20000);
  endtask

  task automatic do_reset(input logic [15:0] r, input logic [15:0] v, input logic [15:0] d,
                          input logic rc, input logic lc);
    @(negedge clk);
    rst = 1'b1;
    ref_set = r; loc_set = v; rate = d; ref_ce = rc; loc_ce = lc;
    repeat (10) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic t_reset();
    int bad = 0;
    @(negedge clk); rst = 1'b1;
    repeat (10) @(negedge clk);
    chk(err == 0 && !err_ovf && !dsp_stb, "R7 reset state", serr(), 0);
    rst = 1'b0;
    while (!dsp_stb) begin
      @(negedge clk);
      if (!dsp_stb && err != 0) bad++;
    end
    chk(bad == 0, "R7 zero before first strobe", bad, 0);
  endtask

  task automatic t_period(input logic [15:0] d, input int exp);
    int n = 0;
    do_reset(16'd14, 16'd6, d, 1'b1, 1'b1);
    wait_stb();
    do begin @(negedge clk); n++; end while (!dsp_stb && n < 20000);
    chk(n == exp, "R4 strobe period", n, exp);
  endtask

  task automatic t_window(input logic [15:0] r, input logic [15:0] v, input logic rc,
                          input logic lc, input int lo, input int hi, input string req, input int nwin);
    do_reset(r, v, 16'd31, rc, lc);
    repeat (2) wait_stb();
    for (int i = 0; i < nwin; i++) begin
      int e;
      wait_stb();
      e = serr();
      chk(e >= lo && e <= hi && !err_ovf, req, e, lo);
    end
  endtask

  task automatic t_hold();
    int e, bad = 0;
    do_reset(16'd14, 16'd6, 16'd31, 1'b0, 1'b1);
    repeat (3) wait_stb();
    e = serr();
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (serr() != e) bad++;
    end
    chk(bad == 0, "R5 err held between strobes", bad, 0);
  endtask

  task automatic t_sat(input logic [15:0] v, input int exp, input bit exp_ovf);
    @(negedge clk); rst = 1'b1; s_loc_set = v;
    repeat (10) @(negedge clk);
    rst = 1'b0;
    repeat (3) begin
      int n = 0;
      do begin @(negedge clk); n++; end while (!s_stb && n < 20000);
    end
    chk(int'($signed(s_err)) == exp, "R6 clipped value", int'($signed(s_err)), exp);
    chk(s_ovf == exp_ovf, "R6 overflow flag", int'(s_ovf), int'(exp_ovf));
  endtask

  initial begin
    t_reset();
    t_period(16'd31, 64);
    t_period(pfd_pkg::DSP_RATE_SUGGESTED, 4096);
    t_window(16'd14, 16'd6, 1'b1, 1'b1, -1, 1, "R8 locked window", 4);
    t_window(16'd14, 16'd14, 1'b1, 1'b1, 3, 5, "R2 slower local divider", 2);
    t_window(16'd30, 16'd6, 1'b1, 1'b1, -5, -3, "R1 slower reference divider", 2);
    t_window(16'd14, 16'd6, 1'b1, 1'b0, 7, 9, "R3 local enable low", 2);
    t_window(16'd14, 16'd6, 1'b0, 1'b1, -8, -8, "R3 reference enable low exact R5", 2);
    t_hold();
    t_sat(16'd0, -8, 1'b1);
    t_sat(16'd14, -4, 1'b0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule